// File: doc/BRIEF.md
# Window Alarm and Interrupt Controller

This block watches the stream of conversion results coming out of a four-channel multiplexed converter. Each result arrives with its channel number. The block takes the eight most significant bits of the result and compares them with that channel's programmable upper and lower limits. A hit on either limit is counted in a trip counter that belongs to that channel. Once the count reaches a programmable number, the channel's alarm latches and stays set. The host clears the alarms and all trip counters by reading the configuration register, and the read is signalled to the block by a strobe.

The block has one interrupt pin. A 3-bit source field chooses what drives it: enabled alarms, converter busy, data ready after one result, or data ready after a full round of four results. The pin can be active high or active low, and it can signal with a level or with a pulse of fixed length. The same source field also chooses which event raises a stop request for the conversion sequencer, and that request is gated by a conversion-control input. A data-ready event is cleared by a strobe that marks the read of a low data byte.

In pulse mode a two-state machine produces the pulse. In `PG_IDLE` the machine waits. A rising edge of the selected event while in pulse mode moves it to `PG_PULSE` and loads the width counter. While in `PG_PULSE`, a new rising edge reloads the counter, so an active pulse is stretched rather than repeated. The machine returns to `PG_IDLE` when the counter expires or when pulse mode is switched off.

Top module: `win_alarm_unit`

## Requirements
- R1: A result trips its channel when its upper eight bits (`res_code[11:4]`) are less than or equal to that channel's lower limit, or greater than or equal to its upper limit. Both bounds are inclusive. Limits are written per channel through `lim_wr`, with `lim_upper`=1 selecting the upper limit.
- R2: Each channel has its own 3-bit trip counter that adds one per trip and saturates at 7. With a nonzero alarm-count setting N (`cfg[7:5]`), the channel's alarm latches on the trip that brings its count to N or above.
- R3: With the alarm-count setting 0, every result on a channel latches that channel's alarm, whether or not it trips.
- R4: Alarms are sticky. `status_o[4+i]` reports the raw alarm of channel i. `status_o[i]` reports that alarm ANDed with enable bit i (written by `en_wr`), so it reads 0 for a disabled channel.
- R5: A pulse on `cfg_rd` clears all alarms and all trip counters. If `cfg_rd` arrives in the same cycle as a result, the clear wins and the result has no effect on the alarms.
- R6: After reset the configuration is E0h: alarm count 7, source 000, active low, level signalling. `int_o` is 1, `stop_req_o` is 0 and `status_o` is 0.
- R7: The source field `cfg[4:2]` selects the interrupt event as follows: 000 enabled alarm, 001/011/111 `conv_busy`, 010 one-result ready, 110 four-result ready. The reserved codes 100 and 101 select no event.
- R8: The one-result-ready flag is set by every result. The four-result-ready flag is set by every fourth result. A `data_lo_rd` strobe clears both flags, except for a flag that a result in the same cycle is setting.
- R9: `cfg[1]`=1 makes the interrupt active high and 0 makes it active low. With `cfg[0]`=0 the interrupt follows the event level. With `cfg[0]`=1, each rising edge of the event gives one active pulse of PULSE_CYC cycles, and a rising edge during a pulse extends it to PULSE_CYC cycles after that edge.
- R10: `stop_req_o` is high while `stop_ctl` is 1 and the stop event is present. The stop event is the enabled alarm for sources 000/001, one-result ready for 010/011, four-result ready for 110/111, and none for the reserved codes. The request stays high until the event is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion result strobe |
| res_chan | input | 2 | Channel of the result |
| res_code | input | 12 | Conversion result code |
| conv_busy | input | 1 | Converter busy level |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration: [7:5] alarm count, [4:2] source, [1] polarity, [0] pulse mode |
| cfg_rd | input | 1 | Configuration-read strobe; clears alarms and counters |
| en_wr | input | 1 | Write strobe for the alarm enables |
| en_wdata | input | 4 | Alarm enable per channel |
| lim_wr | input | 1 | Limit write strobe |
| lim_chan | input | 2 | Channel of the limit write |
| lim_upper | input | 1 | 1 writes the upper limit, 0 the lower |
| lim_wdata | input | 8 | Limit value |
| data_lo_rd | input | 1 | Low-data-byte read strobe; clears data-ready |
| stop_ctl | input | 1 | Conversion-control bit; enables the stop request |
| status_o | output | 8 | Raw alarms [7:4], enabled alarms [3:0] |
| int_o | output | 1 | Interrupt pin |
| stop_req_o | output | 1 | Stop request to the sequencer |

## Verification
The hardest case to reach from the ports is the stretched pulse. The event has to fall and rise again while the machine is still in `PG_PULSE`, which means a data-ready clear and a new result must both land inside the pulse window. The bench schedules them a fixed number of cycles apart, then counts the active cycles and the rising edges of `int_o` over a window several pulse widths long. It expects a single pulse four cycles longer than the nominal width. Another case that needs care is a counter clear that coincides with a result; the bench drives both strobes on the same edge.

// File: rtl/wa_pkg.sv
package wa_pkg;

    localparam int CNT_W = 3;
    localparam logic [7:0] CFG_RESET = 8'hE0;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_ALARM,
        EV_BUSY,
        EV_ONE,
        EV_ALL
    } ev_kind_t;

    typedef struct packed {
        ev_kind_t int_kind;
        ev_kind_t stop_kind;
    } src_map_t;

    typedef enum logic {
        PG_IDLE,
        PG_PULSE
    } pulse_state_t;

    function automatic src_map_t decode_src(input logic [2:0] s);
        src_map_t m;
        unique case (s)
            3'b000:  m = '{int_kind: EV_ALARM, stop_kind: EV_ALARM};
            3'b001:  m = '{int_kind: EV_BUSY,  stop_kind: EV_ALARM};
            3'b010:  m = '{int_kind: EV_ONE,   stop_kind: EV_ONE};
            3'b011:  m = '{int_kind: EV_BUSY,  stop_kind: EV_ONE};
            3'b110:  m = '{int_kind: EV_ALL,   stop_kind: EV_ALL};
            3'b111:  m = '{int_kind: EV_BUSY,  stop_kind: EV_ALL};
            default: m = '{int_kind: EV_NONE,  stop_kind: EV_NONE};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wa_limit_bank.sv
module wa_limit_bank #(
    parameter int NUM_CH = 4,
    parameter int LIM_W  = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr,
    input  logic [CH_W-1:0]                chan,
    input  logic                           upper,
    input  logic [LIM_W-1:0]               wdata,
    output logic [NUM_CH-1:0][LIM_W-1:0]   hi_o,
    output logic [NUM_CH-1:0][LIM_W-1:0]   lo_o
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_lim
        logic sel;
        assign sel = wr && (chan == CH_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_o[i] <= '1;
                lo_o[i] <= '0;
            end else if (sel) begin
                if (upper) hi_o[i] <= wdata;
                else       lo_o[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/wa_chan_alarm.sv
module wa_chan_alarm
    import wa_pkg::*;
#(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [LIM_W-1:0] code,
    input  logic [LIM_W-1:0] lim_hi,
    input  logic [LIM_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] thresh,
    input  logic             clr,
    output logic             alarm_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             trip;

    // inclusive window test on the top bits (R1)
    assign trip    = (code <= lim_lo) || (code >= lim_hi);
    assign cnt_nxt = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            alarm_o <= 1'b0;
        end else if (clr) begin
            cnt_q   <= '0;
            alarm_o <= 1'b0;
        end else if (hit) begin
            if (trip) cnt_q <= cnt_nxt;
            if (thresh == '0) begin
                alarm_o <= 1'b1;
            end else if (trip && (cnt_nxt >= thresh)) begin
                alarm_o <= 1'b1;
            end
        end
    end

    assert_alarm_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o && !clr |=> alarm_o);

    assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0) && !alarm_o);

endmodule

// File: rtl/wa_int_gen.sv
module wa_int_gen
    import wa_pkg::*;
#(
    parameter int PULSE_CYC = 25,
    localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC + 1) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic pulse_mode,
    input  logic active_high,
    output logic int_o
);

    localparam logic [PW-1:0] LOAD = PW'(PULSE_CYC - 1);

    pulse_state_t  state_q, state_d;
    logic [PW-1:0] cnt_q, cnt_d;
    logic          ev_q;
    logic          rise;
    logic          active;

    assign rise = event_i && !ev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
            cnt_q   <= '0;
            ev_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ev_q    <= event_i;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PG_IDLE: begin
                if (pulse_mode && rise) begin
                    state_d = PG_PULSE;
                    cnt_d   = LOAD;
                end
            end
            PG_PULSE: begin
                if (!pulse_mode) begin
                    state_d = PG_IDLE;
                    cnt_d   = '0;
                end else if (rise) begin
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin
                    state_d = PG_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        active = pulse_mode ? (state_q == PG_PULSE) : event_i;
        int_o  = active_high ? active : !active;
    end

    assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_mode && rise |=> state_q == PG_PULSE);

    assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PG_PULSE |-> cnt_q <= LOAD);

endmodule

// File: rtl/win_alarm_unit.sv
module win_alarm_unit
    import wa_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int RES_W     = 12,
    parameter int LIM_W     = 8,
    parameter int PULSE_CYC = 25,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  res_valid,
    input  logic [CH_W-1:0]       res_chan,
    input  logic [RES_W-1:0]      res_code,
    input  logic                  conv_busy,
    input  logic                  cfg_wr,
    input  logic [7:0]            cfg_wdata,
    input  logic                  cfg_rd,
    input  logic                  en_wr,
    input  logic [NUM_CH-1:0]     en_wdata,
    input  logic                  lim_wr,
    input  logic [CH_W-1:0]       lim_chan,
    input  logic                  lim_upper,
    input  logic [LIM_W-1:0]      lim_wdata,
    input  logic                  data_lo_rd,
    input  logic                  stop_ctl,
    output logic [2*NUM_CH-1:0]   status_o,
    output logic                  int_o,
    output logic                  stop_req_o
);

    logic [7:0]                   cfg_q;
    logic [NUM_CH-1:0]            en_q;
    logic [NUM_CH-1:0][LIM_W-1:0] lim_hi, lim_lo;
    logic [NUM_CH-1:0]            alarm;
    logic [LIM_W-1:0]             code_top;
    logic [CH_W-1:0]              scan_q;
    logic                         scan_last;
    logic                         dr1_q, dr4_q;
    logic                         alarm_any;
    src_map_t                     smap;
    logic                         int_ev, stop_ev;

    function automatic logic pick(input ev_kind_t k, input logic al,
                                  input logic bz, input logic d1, input logic d4);
        logic r;
        unique case (k)
            EV_ALARM: r = al;
            EV_BUSY:  r = bz;
            EV_ONE:   r = d1;
            EV_ALL:   r = d4;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
            en_q  <= '0;
        end else begin
            if (cfg_wr) cfg_q <= cfg_wdata;
            if (en_wr)  en_q  <= en_wdata;
        end
    end

    wa_limit_bank #(.NUM_CH(NUM_CH), .LIM_W(LIM_W)) u_lim (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (lim_wr),
        .chan  (lim_chan),
        .upper (lim_upper),
        .wdata (lim_wdata),
        .hi_o  (lim_hi),
        .lo_o  (lim_lo)
    );

    assign code_top = res_code[RES_W-1 -: LIM_W];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = res_valid && (res_chan == CH_W'(i));

        wa_chan_alarm #(.LIM_W(LIM_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit),
            .code    (code_top),
            .lim_hi  (lim_hi[i]),
            .lim_lo  (lim_lo[i]),
            .thresh  (cfg_q[7:5]),
            .clr     (cfg_rd),
            .alarm_o (alarm[i])
        );
    end

    assign status_o = {alarm, alarm & en_q};

    // data-ready tracking (R8)
    assign scan_last = (scan_q == CH_W'(NUM_CH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q <= '0;
            dr1_q  <= 1'b0;
            dr4_q  <= 1'b0;
        end else begin
            if (res_valid) scan_q <= scan_last ? '0 : scan_q + 1'b1;

            if (res_valid)       dr1_q <= 1'b1;
            else if (data_lo_rd) dr1_q <= 1'b0;

            if (res_valid && scan_last) dr4_q <= 1'b1;
            else if (data_lo_rd)        dr4_q <= 1'b0;
        end
    end

    assign alarm_any = |(alarm & en_q);

    always_comb begin
        smap    = decode_src(cfg_q[4:2]);
        int_ev  = pick(smap.int_kind,  alarm_any, conv_busy, dr1_q, dr4_q);
        stop_ev = pick(smap.stop_kind, alarm_any, conv_busy, dr1_q, dr4_q);
    end

    assign stop_req_o = stop_ctl && stop_ev;

    wa_int_gen #(.PULSE_CYC(PULSE_CYC)) u_int (
        .clk         (clk),
        .rst_n       (rst_n),
        .event_i     (int_ev),
        .pulse_mode  (cfg_q[0]),
        .active_high (cfg_q[1]),
        .int_o       (int_o)
    );

    assert_ready_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_lo_rd && !res_valid |=> !dr1_q && !dr4_q);

    assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[4:3] == 2'b10) && !cfg_q[0] |-> int_o == !cfg_q[1]);

    assert_alarm_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ctl && (cfg_q[4:3] == 2'b00) && |(status_o[NUM_CH-1:0]) |-> stop_req_o);

endmodule

// File: tb/win_alarm_unit_tb.sv
module win_alarm_unit_tb;

    localparam int P = 25;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        res_valid, conv_busy, cfg_wr, cfg_rd, en_wr, lim_wr, lim_upper;
    logic        data_lo_rd, stop_ctl;
    logic [1:0]  res_chan, lim_chan;
    logic [11:0] res_code;
    logic [7:0]  cfg_wdata, lim_wdata;
    logic [3:0]  en_wdata;
    logic [7:0]  status_o;
    logic        int_o, stop_req_o;

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    int       m_cnt [4];
    bit [3:0] m_al, m_en;
    bit [7:0] m_cfg;
    bit       m_dr1, m_dr4;
    int       m_scan;
    int       m_hi [4];
    int       m_lo [4];

    // pulse monitor
    bit mon_en = 0;
    int mon_hi, mon_rise;
    bit mon_prev;

    always #5 clk = !clk;

    win_alarm_unit #(.PULSE_CYC(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_code(res_code), .conv_busy(conv_busy), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .en_wr(en_wr), .en_wdata(en_wdata),
        .lim_wr(lim_wr), .lim_chan(lim_chan), .lim_upper(lim_upper),
        .lim_wdata(lim_wdata), .data_lo_rd(data_lo_rd), .stop_ctl(stop_ctl),
        .status_o(status_o), .int_o(int_o), .stop_req_o(stop_req_o)
    );

    always @(negedge clk) begin
        if (mon_en) begin
            if (int_o) mon_hi++;
            if (int_o && !mon_prev) mon_rise++;
            mon_prev = int_o;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input int ch, input int code, input bit rdc, input bit rdl);
        @(negedge clk);
        res_valid = v; res_chan = 2'(ch); res_code = 12'(code);
        cfg_rd = rdc; data_lo_rd = rdl;
        @(negedge clk);
        res_valid = 0; cfg_rd = 0; data_lo_rd = 0;
        if (rdc) begin
            m_al = 0;
            for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        end else if (v) begin
            int h8, th;
            bit tr;
            h8 = (code >> 4) & 255;
            th = m_cfg[7:5];
            tr = (h8 <= m_lo[ch]) || (h8 >= m_hi[ch]);
            if (tr && m_cnt[ch] < 7) m_cnt[ch]++;
            if (th == 0 || (tr && m_cnt[ch] >= th)) m_al[ch] = 1;
        end
        if (v) m_dr1 = 1; else if (rdl) m_dr1 = 0;
        if (v && m_scan == 3) m_dr4 = 1; else if (rdl) m_dr4 = 0;
        if (v) m_scan = (m_scan + 1) % 4;
    endtask

    task automatic set_mode(input bit [7:0] c, input bit bz, input bit sc);
        @(negedge clk);
        cfg_wr = 1; cfg_wdata = c; conv_busy = bz; stop_ctl = sc;
        @(negedge clk);
        cfg_wr = 0;
        m_cfg = c;
    endtask

    task automatic set_en(input bit [3:0] e);
        @(negedge clk);
        en_wr = 1; en_wdata = e;
        @(negedge clk);
        en_wr = 0;
        m_en = e;
    endtask

    task automatic set_lim(input int ch, input int hi, input int lo);
        @(negedge clk);
        lim_wr = 1; lim_chan = 2'(ch); lim_upper = 1; lim_wdata = 8'(hi);
        @(negedge clk);
        lim_upper = 0; lim_wdata = 8'(lo);
        @(negedge clk);
        lim_wr = 0;
        m_hi[ch] = hi; m_lo[ch] = lo;
    endtask

    task automatic check_all(input string tag);
        bit any, iev, sev, exp_int;
        any = |(m_al & m_en);
        case (m_cfg[4:2])
            3'b000: begin iev = any;       sev = any;   end
            3'b001: begin iev = conv_busy; sev = any;   end
            3'b010: begin iev = m_dr1;     sev = m_dr1; end
            3'b011: begin iev = conv_busy; sev = m_dr1; end
            3'b110: begin iev = m_dr4;     sev = m_dr4; end
            3'b111: begin iev = conv_busy; sev = m_dr4; end
            default: begin iev = 0;        sev = 0;     end
        endcase
        chk({tag, " status"}, int'(status_o), int'({m_al, m_al & m_en}));
        if (!m_cfg[0]) begin
            exp_int = m_cfg[1] ? iev : !iev;
            chk({tag, " int"}, int'(int_o), int'(exp_int));
        end
        chk({tag, " stop"}, int'(stop_req_o), int'(stop_ctl && sev));
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; res_valid = 0; res_chan = 0; res_code = 0; conv_busy = 0;
        cfg_wr = 0; cfg_wdata = 0; cfg_rd = 0; en_wr = 0; en_wdata = 0;
        lim_wr = 0; lim_chan = 0; lim_upper = 0; lim_wdata = 0;
        data_lo_rd = 0; stop_ctl = 0;
        m_al = 0; m_en = 0; m_cfg = 8'hE0; m_dr1 = 0; m_dr4 = 0; m_scan = 0;
        for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_hi[i] = 255; m_lo[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R6: reset state
        chk("R6 status", int'(status_o), 0);
        chk("R6 int", int'(int_o), 1);
        chk("R6 stop", int'(stop_req_o), 0);
        check_all("R6");

        // R1 R2 R3 R4: sweep every alarm count over boundary codes
        for (int ch = 0; ch < 4; ch++) set_lim(ch, 8'hC0 - 16 * ch, 8'h30 + 8 * ch);
        for (int th = 0; th < 8; th++) begin
            set_mode(8'((th << 5) | 8'h02), 0, 1);
            set_en(4'((th * 5) & 15));
            cyc(0, 0, 0, 1, 0);
            check_all("R5 clear");
            for (int ch = 0; ch < 4; ch++) begin
                for (int k = 0; k < 6; k++) begin
                    int h8;
                    case (k)
                        0: h8 = m_lo[ch] - 1;
                        1: h8 = m_lo[ch];
                        2: h8 = m_lo[ch] + 1;
                        3: h8 = m_hi[ch] - 1;
                        4: h8 = m_hi[ch];
                        default: h8 = m_hi[ch] + 1;
                    endcase
                    cyc(1, ch, (h8 << 4) | ((k * 5 + ch) & 15), 0, 0);
                    check_all("R1 R2 R3 R4 sweep");
                end
            end
        end

        // R5: counter reset and clear priority
        set_mode(8'h42, 0, 0);
        set_en(4'hF);
        cyc(0, 0, 0, 1, 0);
        cyc(1, 0, 12'hFF0, 0, 0);
        check_all("R5 one trip");
        cyc(0, 0, 0, 1, 0);
        cyc(1, 0, 12'hFF0, 0, 0);
        check_all("R5 counter reset");
        chk("R5 no alarm after clear", int'(status_o[4]), 0);
        cyc(1, 0, 12'h000, 0, 0);
        check_all("R5 second trip");
        set_mode(8'h22, 0, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(1, 1, 12'hFFF, 1, 0);
        check_all("R5 clear wins");
        chk("R5 clear wins status", int'(status_o), 0);

        // R8: same-cycle read and result keeps one-ready set
        set_mode(8'h2A, 0, 0);
        cyc(0, 0, 0, 0, 1);
        check_all("R8 cleared");
        cyc(1, 2, 12'h500, 0, 1);
        check_all("R8 same cycle");
        chk("R8 one-ready kept", int'(int_o), 1);

        // R7 R9 R10: every source, polarity, busy and stop setting in several states
        set_en(4'b0001);
        set_lim(0, 8'h80, 8'h10);
        for (int st = 0; st < 4; st++) begin
            case (st)
                0: begin cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1); end
                1: cyc(1, 1, 12'hFFF, 0, 0);
                2: cyc(1, 0, 12'h900, 0, 0);
                default: begin
                    cyc(0, 0, 0, 0, 1);
                    for (int n = 0; n < 4 && !m_dr4; n++) cyc(1, 2, 12'h500, 0, 0);
                end
            endcase
            for (int s = 0; s < 8; s++)
                for (int pol = 0; pol < 2; pol++)
                    for (int bz = 0; bz < 2; bz++)
                        for (int sc = 0; sc < 2; sc++) begin
                            set_mode(8'(8'h20 | (s << 2) | (pol << 1)), bz[0], sc[0]);
                            check_all("R7 R9 R10 source");
                        end
        end
        set_mode(8'h22, 0, 0);

        // R9: single pulse width
        set_mode(8'h2B, 0, 0);
        cyc(0, 0, 0, 0, 1);
        repeat (P + 4) @(negedge clk);
        mon_hi = 0; mon_rise = 0; mon_prev = int_o; mon_en = 1;
        cyc(1, 2, 12'h500, 0, 0);
        repeat (3 * P) @(negedge clk);
        mon_en = 0;
        chk("R9 pulse width", mon_hi, P);
        chk("R9 pulse count", mon_rise, 1);

        // R9: a new event during the pulse stretches it
        cyc(0, 0, 0, 0, 1);
        repeat (P + 4) @(negedge clk);
        mon_hi = 0; mon_rise = 0; mon_prev = int_o; mon_en = 1;
        cyc(1, 2, 12'h500, 0, 0);
        cyc(0, 0, 0, 0, 1);
        cyc(1, 2, 12'h500, 0, 0);
        repeat (3 * P) @(negedge clk);
        mon_en = 0;
        chk("R9 stretched width", mon_hi, P + 4);
        chk("R9 stretched single", mon_rise, 1);

        // R9: active-low pulse idles high
        set_mode(8'h29, 0, 0);
        repeat (P + 4) @(negedge clk);
        chk("R9 active low idle", int'(int_o), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule